// File: doc/BRIEF.md
# Timer Event Input Action Unit

This block turns two single-bit event lines into control actions for a timer counter that it contains. Each line first passes an enable gate and an optional polarity flip. The resulting post-inversion level goes to a decoder together with a 3-bit action code for that line. The decoder issues commands to the counter: restart, start, stop, count, increment, decrement, direction and capture. The event lines are taken as already synchronous to `clk`.

The two lines have different action menus. Line 0 handles restarting, starting, event counting, level-gated counting, single increments and time-stamping. Line 1 handles restarting, stopping, decrementing, direction control and period/pulse-width measurement. Either line can raise a non-recoverable fault. The counter wraps between zero and `period_i` in both directions. Two capture registers hold measured values.

After reset every action code and enable is zero. The counter sits at zero, stopped, and does nothing until it is configured and an event arrives.

Top module: `tmr_evact_unit`

## Requirements
- R1: After reset, `count_o`, `cap0_o`, `cap1_o` and `fault_o` are all zero and the counter is stopped.
- R2: While `en_i[n]` is 0, line n has no effect at all, whatever its level or action code (including fault code 7).
- R3: When `inv_i[n]` is 1, line n is decoded on its inverted level: a falling raw edge acts as a rising event.
- R4: While running in normal mode, the counter advances one step per clock. Counting up, it wraps from `period_i` to 0.
- R5: Code 1 on either line restarts on a rising event: the count becomes 0 (or `period_i` while counting down) and the counter runs. Code 3 on line 0 sets the counter running and leaves the count unchanged.
- R6: Code 3 on line 1 stops the counter on a rising event. The count keeps its value in that clock and afterwards.
- R7: Line 0 code 2 makes a running counter step once per rising event only. Line 0 code 5 makes it step on every clock while the line level is active.
- R8: Line 0 code 4 adds one per rising event and line 1 code 4 subtracts one per rising event. Both work whether or not the counter runs, and both wrap between 0 and `period_i`.
- R9: Line 1 code 2 makes the counter count down while the line level is active. Counting down, it wraps from 0 to `period_i`.
- R10: Line 0 code 6 copies the count present at the rising event into `cap0_o`.
- R11: Line 1 code 6 measures period and pulse width. A rising event copies the count into `cap1_o` and restarts the counter from 0. A falling event copies the count into `cap0_o`.
- R12: Code 7 on either line sets `fault_o` on a rising event. The counter then stops and the count and captures freeze. Later events are ignored, and only reset clears the flag.
- R13: When both lines request counter updates in one clock, line 0's action is applied and line 1's is dropped. Line 1 code 5 behaves as off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 2 | Event lines, bit n is line n |
| act0_i | input | 3 | Action code for line 0 |
| act1_i | input | 3 | Action code for line 1 |
| inv_i | input | 2 | Per-line polarity flip |
| en_i | input | 2 | Per-line enable |
| period_i | input | CNT_W | Wrap limit of the counter |
| count_o | output | CNT_W | Current count |
| cap0_o | output | CNT_W | Capture register 0 (time stamp or pulse width) |
| cap1_o | output | CNT_W | Capture register 1 (period) |
| fault_o | output | 1 | Sticky fault flag |

## Verification
The collision that matters is line 0 restarting the counter in the same clock that line 1 tries to stop it. The bench raises both lines on the same falling clock edge. It then checks that the count returned to zero and kept advancing, which proves the stop was discarded. A second overlap puts the raising of the fault in the same clock as a normal counting step. The count read back must equal the value before that edge, and it must stay there while further events arrive.

// File: rtl/tmr_evact_pkg.sv
package tmr_evact_pkg;

  typedef enum logic [2:0] {
    A0_OFF    = 3'd0,
    A0_RETRIG = 3'd1,
    A0_CNTEV  = 3'd2,
    A0_START  = 3'd3,
    A0_INC    = 3'd4,
    A0_CNTLVL = 3'd5,
    A0_STAMP  = 3'd6,
    A0_FAULT  = 3'd7
  } act0_e;

  typedef enum logic [2:0] {
    A1_OFF    = 3'd0,
    A1_RETRIG = 3'd1,
    A1_DIR    = 3'd2,
    A1_STOP   = 3'd3,
    A1_DEC    = 3'd4,
    A1_RSVD   = 3'd5,
    A1_PWP    = 3'd6,
    A1_FAULT  = 3'd7
  } act1_e;

  typedef struct packed {
    logic restart;
    logic start;
    logic stop;
    logic inc;
    logic dec;
    logic step;
    logic down;
    logic stamp;
    logic pw_rise;
    logic pw_clr;
    logic pw_fall;
    logic fault;
  } cmd_t;

endpackage

// File: rtl/tmr_evact_gate.sv
module tmr_evact_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic inv_i,
  input  logic en_i,
  output logic lvl_o,
  output logic prv_o
);

  logic prv_q, prv_d;

  assign lvl_o = en_i & (evt_i ^ inv_i);

  always_comb begin
    prv_d = lvl_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv_q <= 1'b0;
    else        prv_q <= prv_d;
  end

  assign prv_o = prv_q;

  p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !lvl_o);

endmodule

// File: rtl/tmr_evact_decode.sv
module tmr_evact_decode
  import tmr_evact_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  lvl_i,
  input  logic [1:0]  prv_i,
  input  logic [2:0]  act0_i,
  input  logic [2:0]  act1_i,
  output cmd_t        cmd_o
);

  logic [1:0] rise, fall;
  act0_e      a0;
  act1_e      a1;
  logic       own0;

  assign rise = lvl_i & ~prv_i;
  assign fall = ~lvl_i & prv_i;
  assign a0   = act0_e'(act0_i);
  assign a1   = act1_e'(act1_i);

  always_comb begin
    cmd_o = '0;
    cmd_o.restart = rise[0] & (a0 == A0_RETRIG);
    cmd_o.start   = rise[0] & (a0 == A0_START);
    cmd_o.inc     = rise[0] & (a0 == A0_INC);
    cmd_o.stamp   = rise[0] & (a0 == A0_STAMP);
    own0 = cmd_o.restart | cmd_o.start | cmd_o.inc;
    // line 1 counter updates yield to line 0 (R13)
    cmd_o.restart = cmd_o.restart | (rise[1] & (a1 == A1_RETRIG) & !own0);
    cmd_o.stop    = rise[1] & (a1 == A1_STOP) & !own0;
    cmd_o.dec     = rise[1] & (a1 == A1_DEC)  & !own0;
    cmd_o.pw_rise = rise[1] & (a1 == A1_PWP);
    cmd_o.pw_clr  = cmd_o.pw_rise & !own0;
    cmd_o.pw_fall = fall[1] & (a1 == A1_PWP);
    cmd_o.down    = lvl_i[1] & (a1 == A1_DIR);
    cmd_o.fault   = (rise[0] & (a0 == A0_FAULT)) | (rise[1] & (a1 == A1_FAULT));
    case (a0)
      A0_CNTEV:  cmd_o.step = rise[0];
      A0_CNTLVL: cmd_o.step = lvl_i[0];
      default:   cmd_o.step = 1'b1;
    endcase
  end

  p_line0_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rise[0] && rise[1] && (a0 == A0_RETRIG) && (a1 == A1_STOP)) |-> !cmd_o.stop);

  p_reserved_off_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (a1 == A1_RSVD) |-> !(cmd_o.stop || cmd_o.dec || cmd_o.pw_rise || cmd_o.down));

endmodule

// File: rtl/tmr_evact_core.sv
module tmr_evact_core
  import tmr_evact_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_t             cmd_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] cap0_o,
  output logic [CNT_W-1:0] cap1_o,
  output logic             fault_o
);

  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d, cap0_q, cap0_d, cap1_q, cap1_d;
  logic [CNT_W-1:0] cnt_up, cnt_dn;
  logic             run_q, run_d, flt_q, flt_d;

  assign cnt_up = (cnt_q == period_i) ? ZERO : cnt_q + ONE;
  assign cnt_dn = (cnt_q == ZERO) ? period_i : cnt_q - ONE;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    cap0_d = cap0_q;
    cap1_d = cap1_q;
    flt_d  = flt_q;
    if (!flt_q) begin
      if (cmd_i.fault) begin
        flt_d = 1'b1;
        run_d = 1'b0;
      end else begin
        if (cmd_i.stamp)        cap0_d = cnt_q;
        else if (cmd_i.pw_fall) cap0_d = cnt_q;
        if (cmd_i.pw_rise)      cap1_d = cnt_q;
        if (cmd_i.restart) begin
          cnt_d = cmd_i.down ? period_i : ZERO;
          run_d = 1'b1;
        end else if (cmd_i.start) begin
          run_d = 1'b1;
        end else if (cmd_i.inc) begin
          cnt_d = cnt_up;
        end else if (cmd_i.stop) begin
          run_d = 1'b0;
        end else if (cmd_i.dec) begin
          cnt_d = cnt_dn;
        end else if (cmd_i.pw_clr) begin
          cnt_d = ZERO;
          run_d = 1'b1;
        end else if (run_q && cmd_i.step) begin
          cnt_d = cmd_i.down ? cnt_dn : cnt_up;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      cap0_q <= '0;
      cap1_q <= '0;
      flt_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      cap0_q <= cap0_d;
      cap1_q <= cap1_d;
      flt_q  <= flt_d;
    end
  end

  assign count_o = cnt_q;
  assign cap0_o  = cap0_q;
  assign cap1_o  = cap1_q;
  assign fault_o = flt_q;

  p_fault_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flt_q |=> flt_q);

  p_fault_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flt_q |=> ($stable(cnt_q) && $stable(cap0_q) && $stable(cap1_q) && !run_q));

  p_stop_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i.stop && !flt_q && !cmd_i.fault) |=> (!run_q && $stable(cnt_q)));

  p_stamp_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i.stamp && !flt_q && !cmd_i.fault) |=> (cap0_q == $past(cnt_q)));

  p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !flt_q && (cnt_q == period_i) && $stable(period_i) && cmd_i.step &&
     !cmd_i.down && !cmd_i.restart && !cmd_i.start && !cmd_i.inc && !cmd_i.stop &&
     !cmd_i.dec && !cmd_i.pw_clr && !cmd_i.fault) |=> (cnt_q == ZERO));

endmodule

// File: rtl/tmr_evact_unit.sv
module tmr_evact_unit
  import tmr_evact_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       evt_i,
  input  logic [2:0]       act0_i,
  input  logic [2:0]       act1_i,
  input  logic [1:0]       inv_i,
  input  logic [1:0]       en_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] cap0_o,
  output logic [CNT_W-1:0] cap1_o,
  output logic             fault_o
);

  localparam int NLINE = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [NLINE-1:0] lvl, prv;
  cmd_t             cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    tmr_evact_gate u_gate (
      .clk   (clk),
      .rst_n (rst_int_n),
      .evt_i (evt_i[g]),
      .inv_i (inv_i[g]),
      .en_i  (en_i[g]),
      .lvl_o (lvl[g]),
      .prv_o (prv[g])
    );
  end

  tmr_evact_decode u_dec (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .lvl_i  (lvl),
    .prv_i  (prv),
    .act0_i (act0_i),
    .act1_i (act1_i),
    .cmd_o  (cmd)
  );

  tmr_evact_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cmd_i    (cmd),
    .period_i (period_i),
    .count_o  (count_o),
    .cap0_o   (cap0_o),
    .cap1_o   (cap1_o),
    .fault_o  (fault_o)
  );

endmodule

// File: tb/tmr_evact_unit_test.sv
module tmr_evact_unit_test;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       evt, inv, en;
  logic [2:0]       act0, act1;
  logic [CNT_W-1:0] period;
  logic [CNT_W-1:0] count, cap0, cap1;
  logic             fault;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  tmr_evact_unit #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .act0_i(act0), .act1_i(act1),
    .inv_i(inv), .en_i(en), .period_i(period),
    .count_o(count), .cap0_o(cap0), .cap1_o(cap1), .fault_o(fault)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [CNT_W-1:0] got, input logic [CNT_W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; evt = '0; inv = '0; en = '0; act0 = '0; act1 = '0; period = 16'd200;
    tick(2);
    rst_n = 1'b1;
    tick(3);
  endtask

  task automatic pulse(input int ln);
    evt[ln] = 1'b1;
    tick(1);
    evt[ln] = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 count", count, 0);
    chk("R1 cap0", cap0, 0);
    chk("R1 cap1", cap1, 0);
    chk("R1 fault", {15'd0, fault}, 0);
    tick(4);
    chk("R1 stopped", count, 0);
  endtask

  task automatic t_run_wrap();
    do_reset();
    period = 16'd7; en = 2'b01; act0 = 3'd1;
    pulse(0);
    chk("R5 retrig to zero", count, 0);
    tick(5);
    chk("R4 free run", count, 5);
    tick(3);
    chk("R4 wrap at period", count, 0);
  endtask

  task automatic t_stop_start();
    do_reset();
    en = 2'b11; act0 = 3'd1; act1 = 3'd3;
    pulse(0);
    tick(3);
    chk("R4 running", count, 3);
    pulse(1);
    chk("R6 stop holds", count, 3);
    tick(4);
    chk("R6 stays stopped", count, 3);
    act0 = 3'd3;
    pulse(0);
    chk("R5 start keeps count", count, 3);
    tick(2);
    chk("R5 start runs", count, 5);
  endtask

  task automatic t_invert();
    do_reset();
    act0 = 3'd1;
    evt[0] = 1'b1; inv[0] = 1'b1; en[0] = 1'b1;
    tick(3);
    chk("R3 raw high idle", count, 0);
    evt[0] = 1'b0;
    tick(1);
    tick(2);
    chk("R3 raw fall starts", count, 2);
  endtask

  task automatic t_enable();
    do_reset();
    act0 = 3'd1; en = 2'b00;
    pulse(0); tick(1); pulse(0);
    tick(3);
    chk("R2 disabled no start", count, 0);
    act1 = 3'd7;
    pulse(1);
    tick(1);
    chk("R2 disabled no fault", {15'd0, fault}, 0);
  endtask

  task automatic t_count_modes();
    do_reset();
    en = 2'b11; act1 = 3'd1; act0 = 3'd2;
    pulse(1);
    tick(4);
    chk("R7 no events no step", count, 0);
    for (int i = 0; i < 3; i++) begin
      pulse(0);
      tick(1);
    end
    chk("R7 count per edge", count, 3);
    act0 = 3'd5;
    evt[0] = 1'b1;
    tick(4);
    chk("R7 count while high", count, 7);
    evt[0] = 1'b0;
    tick(3);
    chk("R7 hold while low", count, 7);
  endtask

  task automatic t_inc_dec();
    do_reset();
    period = 16'd7; en = 2'b11; act0 = 3'd4; act1 = 3'd4;
    for (int i = 0; i < 3; i++) begin pulse(0); tick(1); end
    chk("R8 increments", count, 3);
    for (int i = 0; i < 5; i++) begin pulse(1); tick(1); end
    chk("R8 decrement wraps", count, 6);
    for (int i = 0; i < 2; i++) begin pulse(0); tick(1); end
    chk("R8 increment wraps", count, 0);
  endtask

  task automatic t_direction();
    do_reset();
    period = 16'd9; en = 2'b11; act0 = 3'd1; act1 = 3'd2;
    pulse(0);
    tick(3);
    chk("R9 up while low", count, 3);
    evt[1] = 1'b1;
    tick(5);
    chk("R9 down wraps to period", count, 8);
    pulse(0);
    chk("R5 restart loads period when down", count, 9);
    evt[1] = 1'b0;
  endtask

  task automatic t_stamp();
    do_reset();
    en = 2'b11; act1 = 3'd1;
    pulse(1);
    tick(4);
    act0 = 3'd6;
    pulse(0);
    chk("R10 stamp value", cap0, 4);
    chk("R10 counter goes on", count, 5);
  endtask

  task automatic t_pwp();
    do_reset();
    en = 2'b10; act1 = 3'd6;
    evt[1] = 1'b1;
    tick(5);
    chk("R11 restarted on rise", count, 4);
    evt[1] = 1'b0;
    tick(1);
    chk("R11 width into cap0", cap0, 4);
    tick(2);
    evt[1] = 1'b1;
    tick(1);
    chk("R11 period into cap1", cap1, 7);
    chk("R11 count cleared", count, 0);
    evt[1] = 1'b0;
  endtask

  task automatic t_priority();
    do_reset();
    en = 2'b11; act0 = 3'd1; act1 = 3'd3;
    pulse(0);
    tick(3);
    evt = 2'b11;
    tick(1);
    chk("R13 line0 restart wins", count, 0);
    tick(2);
    chk("R13 stop dropped", count, 2);
    evt = 2'b00;
    act1 = 3'd5;
    tick(1);
    pulse(1);
    tick(1);
    chk("R13 reserved code off", count, 5);
  endtask

  task automatic t_fault();
    do_reset();
    en = 2'b11; act0 = 3'd1; act1 = 3'd7;
    pulse(0);
    tick(3);
    pulse(1);
    chk("R12 fault set", {15'd0, fault}, 1);
    chk("R12 count frozen", count, 3);
    tick(5);
    chk("R12 still frozen", count, 3);
    pulse(0);
    tick(2);
    chk("R12 events blocked", count, 3);
    chk("R12 fault sticky", {15'd0, fault}, 1);
    do_reset();
    chk("R12 cleared by reset", {15'd0, fault}, 0);
  endtask

  initial begin
    rst_n = 1'b0; evt = '0; inv = '0; en = '0; act0 = '0; act1 = '0; period = '0;
    t_reset();
    t_run_wrap();
    t_stop_start();
    t_invert();
    t_enable();
    t_count_modes();
    t_inc_dec();
    t_direction();
    t_stamp();
    t_pwp();
    t_priority();
    t_fault();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule